// File: doc/BRIEF.md
# Overcurrent Limit and Shutdown Timer

This block sits between a sampled current-limit comparator and the gate-drive logic of a synchronous buck controller. Once per switching cycle the comparator produces a flag that says whether the sampled output current is above the limit. When a valid sample is over the limit, the block cuts the drive pulse for the rest of that switching cycle. The first such sample also starts a long qualification timer.

The timer has a decision window. It opens `WIN_OPEN` clocks after arming and closes `WIN_CLOSE` clocks after arming. With the defaults and a 125 MHz clock, these are about 26 ms and 53 ms. An over-limit sample inside that window latches a shutdown, which holds both gate enables low. Over-limit samples that arrive before the window opens still cut their own pulse, but they do not decide anything and they do not restart the timer. If the window closes without another over-limit sample, the timer returns to idle and normal monitoring resumes. The shutdown clears only on reset or when the enable input goes low.

Top module: `ocp_shutdown_timer`

## Requirements
- R1: After reset, `pulse_kill` and `shutdown` are 0, and `hs_en`/`ls_en` follow `en`.
- R2: A sample with `samp_vld`=1 and `samp_over`=1 (while enabled and not shut down) sets `pulse_kill` on the next clock edge. `pulse_kill` stays 1 until a clock edge where `cyc_start`=1 arrives with no new over-limit sample; if a new over-limit sample arrives in the same cycle as `cyc_start`, `pulse_kill` stays 1.
- R3: An over-limit sample while the timer is idle arms the timer with its count at 0 and does not cause a shutdown.
- R4: While armed, the count advances by one per clock. An over-limit sample seen while the count is between `WIN_OPEN` and `WIN_CLOSE` inclusive sets `shutdown` at that clock edge.
- R5: Over-limit samples seen while the count is below `WIN_OPEN` cause no shutdown and do not restart the count.
- R6: If the count reaches `WIN_CLOSE` with no shutdown, the timer returns to idle. The next over-limit sample re-arms the timer instead of tripping it.
- R7: Once set, `shutdown` stays 1 while `en`=1. Further samples neither clear it nor set `pulse_kill`. `hs_en` and `ls_en` are 0 while `shutdown`=1 or `en`=0.
- R8: `en`=0 clears `shutdown`, `pulse_kill` and the timer at the next edge, and samples taken while `en`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low clears all state |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| samp_vld | input | 1 | Comparator sample valid strobe |
| samp_over | input | 1 | Sampled current is above the limit |
| pulse_kill | output | 1 | Ends the drive pulse for the current switching cycle |
| shutdown | output | 1 | Latched overcurrent shutdown |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The assertions assume that `samp_over` only matters when `samp_vld` is high, and that `samp_vld` and `cyc_start` are single-clock strobes. They also assume `en` changes only between clock edges. The stimulus drives every input on the falling edge and holds each strobe for exactly one clock. It also lowers `en` for one clock between scenarios, so each window case starts from an idle timer. The window parameters are shrunk to 20 and 40 clocks so that the inclusive edges (counts 19, 20, 40 and 41) can be reached directly.

// File: rtl/ocp_shutdown_timer.sv
module ocp_shutdown_timer #(
  parameter int unsigned WIN_OPEN  = 3_250_000,
  parameter int unsigned WIN_CLOSE = 6_625_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic samp_vld,
  input  logic samp_over,
  output logic pulse_kill,
  output logic shutdown,
  output logic hs_en,
  output logic ls_en
);
  localparam int CW = $clog2(WIN_CLOSE + 1);
  localparam logic [CW-1:0] OPEN_C  = CW'(WIN_OPEN);
  localparam logic [CW-1:0] CLOSE_C = CW'(WIN_CLOSE);

  logic          armed;
  logic [CW-1:0] cnt;

  wire hit    = samp_vld & samp_over & en & ~shutdown;
  wire in_win = armed & (cnt >= OPEN_C);

  assign hs_en = en & ~shutdown;
  assign ls_en = en & ~shutdown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      shutdown <= 1'b0;
    end else if (!en) begin
      armed    <= 1'b0;
      cnt      <= '0;
      shutdown <= 1'b0;
    end else if (hit && in_win) begin
      shutdown <= 1'b1;
      armed    <= 1'b0;
      cnt      <= '0;
    end else if (armed) begin
      if (cnt == CLOSE_C) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (hit) begin
      armed <= 1'b1;
      cnt   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse_kill <= 1'b0;
    else if (!en)       pulse_kill <= 1'b0;
    else if (hit)       pulse_kill <= 1'b1;
    else if (cyc_start) pulse_kill <= 1'b0;
  end

  assert_kill_on_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_vld && samp_over && en && !shutdown) |=> pulse_kill);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CLOSE_C);

  assert_no_early_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> ($past(cnt) >= OPEN_C));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && en) |=> shutdown);

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!shutdown && !pulse_kill));
endmodule

// File: tb/sim_ocp_shutdown_timer.sv
module sim_ocp_shutdown_timer;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cyc_start = 1'b0, samp_vld = 1'b0, samp_over = 1'b0;
  logic pulse_kill, shutdown, hs_en, ls_en;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ocp_shutdown_timer #(.WIN_OPEN(20), .WIN_CLOSE(40)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
    .samp_vld(samp_vld), .samp_over(samp_over),
    .pulse_kill(pulse_kill), .shutdown(shutdown), .hs_en(hs_en), .ls_en(ls_en));

  // {target count when second sample lands, expected shutdown}
  localparam logic [16:0] VEC [6] = '{
    {16'd5,  1'b0}, {16'd19, 1'b0}, {16'd20, 1'b1},
    {16'd30, 1'b1}, {16'd40, 1'b1}, {16'd41, 1'b0}};

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic pulse_over();
    @(negedge clk); samp_vld = 1'b1; samp_over = 1'b1;
    @(negedge clk); samp_vld = 1'b0; samp_over = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    chk(pulse_kill, 1'b0, "R1 kill at reset");
    chk(shutdown, 1'b0, "R1 shutdown at reset");
    rst_n = 1'b1; en = 1'b1;
    idle(1);
    chk(hs_en, 1'b1, "R1 hs_en follows en");

    for (int i = 0; i < 6; i++) begin
      restart();
      pulse_over();
      chk(shutdown, 1'b0, "R3 arm no trip");
      idle(int'(VEC[i][16:1]) - 1);
      pulse_over();
      chk(shutdown, VEC[i][0], $sformatf("R4/R6 window count %0d", VEC[i][16:1]));
    end

    // R6: after expiry the late sample re-armed; a sample at count 25 now trips
    idle(25 - (-1) - 2);
    pulse_over();
    chk(shutdown, 1'b1, "R6 re-armed then trip");

    // R2 kill set and cleared by cycle start
    restart();
    pulse_over();
    chk(pulse_kill, 1'b1, "R2 kill set");
    idle(2);
    chk(pulse_kill, 1'b1, "R2 kill held");
    @(negedge clk); cyc_start = 1'b1; samp_vld = 1'b1; samp_over = 1'b1;
    @(negedge clk); cyc_start = 1'b0; samp_vld = 1'b0; samp_over = 1'b0;
    chk(pulse_kill, 1'b1, "R2 set wins over cycle start");
    @(negedge clk); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    chk(pulse_kill, 1'b0, "R2 kill cleared");

    // R5 early sample kills but does not restart count
    restart();
    pulse_over();
    @(negedge clk); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    idle(5 - (-1) - 2 - 2);
    pulse_over();
    chk(pulse_kill, 1'b1, "R5 early sample kills");
    chk(shutdown, 1'b0, "R5 early no trip");
    idle(25 - 5 - 2);
    pulse_over();
    chk(shutdown, 1'b1, "R5 count not restarted");

    // R7 latch holds, samples ignored, gates low
    chk(hs_en, 1'b0, "R7 hs_en low");
    chk(ls_en, 1'b0, "R7 ls_en low");
    @(negedge clk); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    pulse_over();
    chk(pulse_kill, 1'b0, "R7 no kill while shut");
    idle(50);
    chk(shutdown, 1'b1, "R7 latch holds");

    // R8 enable low clears and blocks samples
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(shutdown, 1'b0, "R8 shutdown cleared");
    chk(ls_en, 1'b0, "R8 ls_en low when disabled");
    pulse_over();
    chk(pulse_kill, 1'b0, "R8 sample ignored when disabled");
    en = 1'b1;
    idle(24);
    pulse_over();
    chk(shutdown, 1'b0, "R8 disabled sample did not arm");
    chk(hs_en, 1'b1, "R8 gates back on");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule